// File: doc/BRIEF.md
# Comma Search Enable Controller

This block sits beside one receive lane of a serial transceiver and decides when the word aligner may hunt for comma characters. A global arm input turns it on. While it is armed and has not locked, it holds both comma-search enables high: one for the positive-disparity comma and one for the negative-disparity comma. This lets the aligner slide the word boundary until the received words make sense.

Once the pattern checker reports that the link is up, the block watches the received word stream for the idle word. When it sees an unbroken run of idle words, it latches an aligned flag and drops both enables. This freezes the word boundary so that later random data cannot move it. Disarming the block, or resetting it, starts the process again.

The data width, the idle word, a match mask and the length of the idle run are parameters. All logic runs on the receive user clock and uses a synchronous active-high reset.

Top module: `comma_search_ctrl`

## Requirements
- R1: While `search_arm` is low, `plus_comma_en` and `minus_comma_en` are low. `aligned` is low from the first clock edge that samples `search_arm` low, and link-up or idle words received while disarmed have no effect.
- R2: `plus_comma_en` and `minus_comma_en` always carry the same value. Both are high whenever `search_arm` is high and `aligned` is low.
- R3: The block does not count idle words until it has sampled `link_up` high once while searching. The word received on that sampling edge is not counted.
- R4: After that edge, a run of IDLE_RUN (default 7) consecutive idle words, sampled with `link_up` high, sets `aligned` on the edge that samples the last word of the run. A word is idle when `(rx_word & IDLE_MASK) == (IDLE_WORD & IDLE_MASK)`; the defaults are `16'h50BC` and all ones.
- R5: On the edge where `aligned` rises, both comma enables fall at the same time.
- R6: A non-idle word received during counting clears the run. A further full run of IDLE_RUN idle words is then needed.
- R7: If `link_up` drops before alignment, the block returns to searching with the run cleared. A fresh link-up sample and a full run are then needed.
- R8: Once set, `aligned` stays high, and the enables stay low, whatever `link_up` and `rx_word` do, for as long as `search_arm` stays high.
- R9: A synchronous `rst` clears `aligned` and the idle run. Directly after reset the enables equal `search_arm`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive user clock |
| rst | input | 1 | Synchronous reset, active high |
| search_arm | input | 1 | Global comma-alignment arm |
| link_up | input | 1 | Link-up indication from the pattern checker |
| rx_word | input | DATA_W | Received data word, one per clock |
| plus_comma_en | output | 1 | Enable for the positive-disparity comma search |
| minus_comma_en | output | 1 | Enable for the negative-disparity comma search |
| aligned | output | 1 | Alignment latched |

## Verification
The assertions take for granted that `rx_word`, `link_up` and `search_arm` are settled before each rising edge, so that one word is sampled per cycle. They also assume that `rst` is held high over the first edge, so that no property looks into a history from before reset. The bench changes inputs only just after a rising edge and holds them for a full cycle. It starts every scenario from a reset. It breaks the idle run at every position from zero to six words, so the count is always a known arithmetic distance from IDLE_RUN.

// File: rtl/csc_pkg.sv
package csc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SEARCH  = 2'd1,
        ST_COUNT   = 2'd2,
        ST_ALIGNED = 2'd3
    } csc_state_e;

    typedef struct packed {
        csc_state_e state;
        logic       aligned;
    } csc_ctl_t;

endpackage

// File: rtl/csc_idle_match.sv
module csc_idle_match #(
    parameter int                DATA_W    = 16,
    parameter logic [DATA_W-1:0] IDLE_WORD = 16'h50BC,
    parameter logic [DATA_W-1:0] IDLE_MASK = '1
) (
    input  logic [DATA_W-1:0] word_i,
    output logic              hit_o
);

    localparam bit FULL_MASK = (IDLE_MASK == {DATA_W{1'b1}});

    generate
        if (FULL_MASK) begin : g_exact
            assign hit_o = (word_i == IDLE_WORD);
        end else begin : g_masked
            assign hit_o = ((word_i & IDLE_MASK) == (IDLE_WORD & IDLE_MASK));
        end
    endgenerate

endmodule

// File: rtl/csc_run_counter.sv
module csc_run_counter #(
    parameter int RUN = 7,
    localparam int CW = $clog2(RUN + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          inc_i,
    output logic          done_o,
    output logic [CW-1:0] count_o
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!inc_i) begin
            cnt_d = '0;
        end else if (cnt_q == CW'(RUN - 1)) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign done_o  = inc_i && (cnt_q == CW'(RUN - 1));
    assign count_o = cnt_q;

    // R4
    run_cap_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q < CW'(RUN));

    // R6
    run_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !inc_i |=> cnt_q == '0);

endmodule

// File: rtl/comma_search_ctrl.sv
module comma_search_ctrl
    import csc_pkg::*;
#(
    parameter int                DATA_W    = 16,
    parameter logic [DATA_W-1:0] IDLE_WORD = 16'h50BC,
    parameter logic [DATA_W-1:0] IDLE_MASK = '1,
    parameter int                IDLE_RUN  = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              search_arm,
    input  logic              link_up,
    input  logic [DATA_W-1:0] rx_word,
    output logic              plus_comma_en,
    output logic              minus_comma_en,
    output logic              aligned
);

    localparam int CNT_W = $clog2(IDLE_RUN + 1);

    csc_ctl_t        ctl_d, ctl_q;
    logic            idle_hit;
    logic            run_inc;
    logic            run_done;
    logic [CNT_W-1:0] run_count;

    csc_idle_match #(
        .DATA_W    (DATA_W),
        .IDLE_WORD (IDLE_WORD),
        .IDLE_MASK (IDLE_MASK)
    ) u_match (
        .word_i (rx_word),
        .hit_o  (idle_hit)
    );

    assign run_inc = search_arm && link_up && idle_hit && (ctl_q.state == ST_COUNT);

    csc_run_counter #(
        .RUN (IDLE_RUN)
    ) u_run (
        .clk     (clk),
        .rst     (rst),
        .inc_i   (run_inc),
        .done_o  (run_done),
        .count_o (run_count)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (!search_arm) begin
            ctl_d.state = ST_IDLE;
        end else begin
            unique case (ctl_q.state)
                ST_IDLE:    ctl_d.state = ST_SEARCH;
                ST_SEARCH:  if (link_up) ctl_d.state = ST_COUNT;
                ST_COUNT: begin
                    if (!link_up)      ctl_d.state = ST_SEARCH;
                    else if (run_done) ctl_d.state = ST_ALIGNED;
                end
                ST_ALIGNED: ctl_d.state = ST_ALIGNED;
                default:    ctl_d.state = ST_IDLE;
            endcase
        end
        ctl_d.aligned = (ctl_d.state == ST_ALIGNED);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q.state   <= ST_IDLE;
            ctl_q.aligned <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign aligned        = ctl_q.aligned;
    assign plus_comma_en  = search_arm && !ctl_q.aligned;
    assign minus_comma_en = search_arm && !ctl_q.aligned;

    // R4
    align_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(aligned) |-> $past(link_up) && $past(idle_hit) && $past(search_arm));

    // R1
    disarm_chk: assert property (@(posedge clk) disable iff (rst)
        !search_arm |=> !aligned);

    // R8
    latch_chk: assert property (@(posedge clk) disable iff (rst)
        (aligned && search_arm) |=> aligned);

    // R7
    link_loss_chk: assert property (@(posedge clk) disable iff (rst)
        (search_arm && !link_up && ctl_q.state == ST_COUNT) |=> ctl_q.state == ST_SEARCH);

    // R3
    no_count_early_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.state == ST_SEARCH) |=> run_count == '0);

endmodule

// File: tb/comma_search_ctrl_bench.sv
module comma_search_ctrl_bench;

    localparam logic [15:0] IDLE  = 16'h50BC;
    localparam logic [15:0] OTHER = 16'h1234;
    localparam int          RUN   = 7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        search_arm = 1'b0;
    logic        link_up = 1'b0;
    logic [15:0] rx_word = '0;
    logic        plus_comma_en, minus_comma_en, aligned;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    comma_search_ctrl #(
        .DATA_W    (16),
        .IDLE_WORD (IDLE),
        .IDLE_RUN  (RUN)
    ) u_comma_search_ctrl (
        .clk            (clk),
        .rst            (rst),
        .search_arm     (search_arm),
        .link_up        (link_up),
        .rx_word        (rx_word),
        .plus_comma_en  (plus_comma_en),
        .minus_comma_en (minus_comma_en),
        .aligned        (aligned)
    );

    task automatic tick(input logic a, input logic l, input logic [15:0] d);
        search_arm = a;
        link_up    = l;
        rx_word    = d;
        @(posedge clk);
        #1;
    endtask

    // expected value order: {aligned, plus, minus}
    task automatic chk(input string req, input logic [2:0] exp);
        logic [2:0] got;
        got = {aligned, plus_comma_en, minus_comma_en};
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    task automatic do_reset(input logic a);
        rst = 1'b1;
        tick(a, 1'b0, '0);
        tick(a, 1'b0, '0);
        rst = 1'b0;
    endtask

    // arm, go to search, then one link-up sample that enters counting
    task automatic enter_count();
        tick(1'b1, 1'b0, OTHER);
        tick(1'b1, 1'b0, OTHER);
        tick(1'b1, 1'b1, OTHER);
    endtask

    task automatic idles(input int n);
        for (int i = 0; i < n; i++) tick(1'b1, 1'b1, IDLE);
    endtask

    task automatic finish_up();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        finished = 1'b1;
        $finish;
    endtask

    initial begin
        #1;
        // R1 reset state disarmed
        do_reset(1'b0);
        chk("R1 reset disarmed", 3'b000);
        // R9 reset while armed enables search straight away
        rst = 1'b1;
        search_arm = 1'b1;
        #1;
        chk("R9 reset armed", 3'b011);
        do_reset(1'b1);
        chk("R9 after reset armed", 3'b011);

        // R1 disarmed link and idles ignored
        do_reset(1'b0);
        for (int i = 0; i < 12; i++) tick(1'b0, 1'b1, IDLE);
        chk("R1 disarmed idles", 3'b000);

        // R3 no link: idles never align, enables held (R2)
        do_reset(1'b1);
        for (int i = 0; i < 20; i++) tick(1'b1, 1'b0, IDLE);
        chk("R3 no link", 3'b011);
        chk("R2 enables while searching", 3'b011);
        // link sampled with an idle word: that word is not counted
        tick(1'b1, 1'b1, IDLE);
        idles(RUN - 1);
        chk("R3 link word not counted", 3'b011);
        idles(1);
        chk("R3 aligned after full run", 3'b100);

        // R4 plain run, checked on each edge
        do_reset(1'b1);
        enter_count();
        for (int k = 1; k <= RUN; k++) begin
            idles(1);
            chk("R4 run progress", (k == RUN) ? 3'b100 : 3'b011);
        end
        chk("R5 enables drop", 3'b100);

        // R6 sweep of break positions
        for (int p = 0; p < RUN; p++) begin
            do_reset(1'b1);
            enter_count();
            idles(p);
            chk("R6 before break", 3'b011);
            tick(1'b1, 1'b1, OTHER);
            idles(RUN - 1);
            chk("R6 one short after break", 3'b011);
            idles(1);
            chk("R6 aligned after break", 3'b100);
        end

        // R7 link loss mid run
        for (int p = 1; p < RUN; p++) begin
            do_reset(1'b1);
            enter_count();
            idles(p);
            tick(1'b1, 1'b0, IDLE);
            tick(1'b1, 1'b1, IDLE);
            idles(RUN - 1);
            chk("R7 one short after link loss", 3'b011);
            idles(1);
            chk("R7 aligned after relink", 3'b100);
        end

        // R8 latched against link loss and data
        do_reset(1'b1);
        enter_count();
        idles(RUN);
        for (int i = 0; i < 10; i++) tick(1'b1, i[0], OTHER ^ 16'(i));
        chk("R8 latched", 3'b100);

        // R1 disarm clears aligned, re-arm needs a fresh run
        tick(1'b0, 1'b1, IDLE);
        chk("R1 disarm clears", 3'b000);
        tick(1'b1, 1'b1, IDLE);
        chk("R1 rearm searches", 3'b011);
        tick(1'b1, 1'b1, IDLE);
        idles(RUN - 1);
        chk("R1 rearm short", 3'b011);
        idles(1);
        chk("R1 rearm aligned", 3'b100);

        // R9 reset while aligned and armed
        rst = 1'b1;
        tick(1'b1, 1'b1, IDLE);
        chk("R9 reset clears aligned", 3'b011);
        rst = 1'b0;
        tick(1'b1, 1'b1, IDLE);
        idles(RUN - 1);
        chk("R9 run restarted", 3'b011);

        finish_up();
    end

    initial begin
        #1000000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_up();
        end
    end

endmodule